// File: doc/BRIEF.md
# Serial Presence-Detect Store

This block is a 256-byte configuration store that a host reads over a two-wire serial bus made of a clock line and a data line. It sits on a memory module and tells the host how the module is built: memory type, row and column address widths, bank count, data width and timing bytes. After reset the store holds the module description. Byte 63 holds a self-checksum over bytes 0 to 62. The unused vendor area (64 to 125) reads as 0xFF and everything from 128 upward reads as 0x00.

The block samples both bus lines with the system clock. It detects START and STOP conditions, shifts in the device address, word address and data bytes, and acknowledges them. It shifts out read data. The 7-bit device address is the fixed type code 1010 followed by the three strap inputs, most significant strap first. A host can do a random read (set the pointer, repeated START, read), a sequential read (the pointer advances after each byte and wraps from 255 to 0) and byte writes. A write-protect input lets writes be acknowledged but keeps them out of the array. The output `checksum_ok` compares the stored byte 63 with the live sum of bytes 0 to 62.

The open-drain data pin is modelled as `sda_oe`: when it is high the block pulls the data line low.

Top module: `spd_serial_store`

Controller states and transitions:
- IDLE: waits here until a START arrives.
- DEVADDR: collects 8 bits. On a matching address it goes to ACK_DEV; on any other address it returns to IDLE.
- ACK_DEV: on the next falling edge it goes to RDATA if the direction bit is 1, otherwise to WORD.
- WORD: after 8 bits it loads the pointer and goes to ACK_WORD.
- ACK_WORD: goes to WDATA.
- WDATA: after 8 bits it stores the byte (unless write-protect is high) and goes to ACK_WDATA.
- ACK_WDATA: goes back to WDATA.
- RDATA: after 8 bits it goes to MACK.
- MACK: if the host sent an ACK it goes to RDATA; if it sent a NACK it goes to IDLE.
- START from any state goes to DEVADDR. STOP from any state goes to IDLE.

## Requirements
- R1: After reset `sda_oe` is 0 and `checksum_ok` is 1.
- R2: The block acknowledges only the device address whose upper four bits are 1010 and whose lower three bits equal `sa[2:0]`, followed by the direction bit (0 = write, 1 = read). For any other address it never drives the line, and it stays released while idle.
- R3: A random read returns these preset bytes: byte 0 = 0x80, byte 1 = 0x08, byte 2 = 0x04, byte 3 = 0x0C, byte 4 = 0x09, byte 5 = 0x02, byte 6 = 0x40, byte 62 = 0x12.
- R4: After reset, bytes 64 to 125 read 0xFF and bytes 128 to 255 read 0x00.
- R5: After reset, byte 63 equals the low 8 bits of the sum of bytes 0 to 62.
- R6: A sequential read advances the pointer by one after each byte and wraps from 255 to 0.
- R7: A byte write with `wp` low is acknowledged and stored, and a later read returns the byte.
- R8: With `wp` high, the data byte of a write is still acknowledged, but the array and `checksum_ok` do not change.
- R9: `checksum_ok` goes to 0 when a write makes byte 63 differ from the sum of bytes 0 to 62, and it returns to 1 when the sum matches again.
- R10: Bytes are sent most significant bit first. The block changes `sda_oe` only while the clock line is low. A STOP releases the line. A repeated START restarts address decoding.
- R11: A NACK from the host after a read byte ends the transfer, and the block does not drive the line afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset; reloads the preset contents |
| scl | input | 1 | Serial bus clock line |
| sda_in | input | 1 | Level of the serial data line |
| sda_oe | output | 1 | 1 pulls the data line low |
| sa | input | 3 | Strap inputs; the low three bits of the device address |
| wp | input | 1 | Write protect; 1 blocks storage of written bytes |
| checksum_ok | output | 1 | 1 when byte 63 equals the sum of bytes 0 to 62 |

## Verification
The hardest case to reach from the ports is the pointer wrap from 255 to 0 during a sequential read. The bench reaches it by first setting the pointer to 254 with a write header and no data, then issuing a repeated START and reading four bytes; the last two must be bytes 0 and 1. The checksum byte is checked by reading bytes 0 through 63 in one sequential burst and summing them in the bench. Write protection is checked by watching both the data acknowledge and the read-back value, and by writing a checksum-relevant byte while `checksum_ok` must hold steady.

// File: rtl/spd_pkg.sv
package spd_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEVADDR,
        S_ACK_DEV,
        S_WORD,
        S_ACK_WORD,
        S_WDATA,
        S_ACK_WDATA,
        S_RDATA,
        S_MACK
    } spd_state_e;

    // Preset contents of the module description (checksum byte excluded).
    function automatic logic [7:0] spd_preset(input int idx);
        logic [7:0] v;
        if (idx >= 128)                   v = 8'h00;
        else if (idx >= 64 && idx <= 125) v = 8'hFF;
        else begin
            case (idx)
                0:  v = 8'h80;   1:  v = 8'h08;   2:  v = 8'h04;   3:  v = 8'h0C;
                4:  v = 8'h09;   5:  v = 8'h02;   6:  v = 8'h40;   8:  v = 8'h01;
                9:  v = 8'hA0;   10: v = 8'h60;   12: v = 8'h80;   13: v = 8'h08;
                15: v = 8'h01;   16: v = 8'h8F;   17: v = 8'h04;   18: v = 8'h06;
                19: v = 8'h01;   20: v = 8'h01;   22: v = 8'h06;   23: v = 8'hA0;
                24: v = 8'h60;   27: v = 8'h14;   28: v = 8'h10;   29: v = 8'h14;
                30: v = 8'h2D;   31: v = 8'h10;   32: v = 8'h20;   33: v = 8'h10;
                34: v = 8'h20;   35: v = 8'h10;   62: v = 8'h12;
                126: v = 8'h64;  127: v = 8'hAF;
                default: v = 8'h00;
            endcase
        end
        return v;
    endfunction

    function automatic logic [7:0] spd_preset_sum(input int upto);
        logic [7:0] acc;
        acc = 8'h00;
        for (int i = 0; i < upto; i++) acc = acc + spd_preset(i);
        return acc;
    endfunction

endpackage

// File: rtl/spd_line_sync.sv
module spd_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl};
            sda_sh <= {sda_sh[STAGES-2:0], sda};
            scl_q  <= scl_sh[STAGES-1];
            sda_q  <= sda_sh[STAGES-1];
        end
    end

    assign scl_lvl   = scl_sh[STAGES-1];
    assign sda_lvl   = sda_sh[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/spd_store.sv
module spd_store
    import spd_pkg::*;
#(
    parameter int AW       = 8,
    parameter int CSUM_IDX = 63
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    output logic          checksum_ok
);
    localparam int DEPTH = 1 << AW;
    localparam logic [7:0] PRESET_SUM = spd_preset_sum(CSUM_IDX);

    logic [7:0] mem [DEPTH];
    logic [7:0] acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= (i == CSUM_IDX) ? PRESET_SUM : spd_preset(i);
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

    always_comb begin
        acc = 8'h00;
        for (int i = 0; i < CSUM_IDX; i++) acc = acc + mem[i];
    end

    assign checksum_ok = (acc == mem[CSUM_IDX]);
endmodule

// File: rtl/spd_serial_store.sv
module spd_serial_store
    import spd_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE    = 4'b1010,
    parameter int         AW          = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl,
    input  logic       sda_in,
    output logic       sda_oe,
    input  logic [2:0] sa,
    input  logic       wp,
    output logic       checksum_ok
);
    localparam int CW = 4;

    spd_state_e     state, nxt;
    logic           scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0]     shreg, rdata;
    logic [CW-1:0]  cnt;
    logic [AW-1:0]  ptr;
    logic           oe, rw, nack;
    logic           byte_done, dev_match, mem_we;

    spd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    assign byte_done = (cnt == CW'(8));
    assign dev_match = (shreg[7:1] == {DEV_TYPE, sa});
    assign mem_we    = scl_fall && !start_det && !stop_det &&
                       (state == S_WDATA) && byte_done && !wp;

    spd_store #(.AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(ptr),
        .wdata(shreg), .rdata(rdata), .checksum_ok(checksum_ok)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        if (stop_det)       nxt = S_IDLE;
        else if (start_det) nxt = S_DEVADDR;
        else if (scl_fall) begin
            unique case (state)
                S_IDLE:      nxt = S_IDLE;
                S_DEVADDR:   if (byte_done) nxt = dev_match ? S_ACK_DEV : S_IDLE;
                S_ACK_DEV:   nxt = rw ? S_RDATA : S_WORD;
                S_WORD:      if (byte_done) nxt = S_ACK_WORD;
                S_ACK_WORD:  nxt = S_WDATA;
                S_WDATA:     if (byte_done) nxt = S_ACK_WDATA;
                S_ACK_WDATA: nxt = S_WDATA;
                S_RDATA:     if (byte_done) nxt = S_MACK;
                S_MACK:      nxt = nack ? S_IDLE : S_RDATA;
                default:     nxt = S_IDLE;
            endcase
        end
    end

    // Output and datapath process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
            ptr   <= '0;
            oe    <= 1'b0;
            rw    <= 1'b0;
            nack  <= 1'b0;
        end else if (start_det || stop_det) begin
            cnt <= '0;
            oe  <= 1'b0;
        end else if (scl_rise) begin
            if (state == S_DEVADDR || state == S_WORD || state == S_WDATA) begin
                shreg <= {shreg[6:0], sda_lvl};
                cnt   <= cnt + CW'(1);
            end else if (state == S_RDATA) begin
                cnt <= cnt + CW'(1);
            end else if (state == S_MACK) begin
                nack <= sda_lvl;
            end
        end else if (scl_fall) begin
            unique case (state)
                S_DEVADDR: if (byte_done) begin
                    cnt <= '0;
                    oe  <= dev_match;
                    rw  <= shreg[0];
                end
                S_ACK_DEV: begin
                    if (rw) begin
                        shreg <= rdata;
                        oe    <= ~rdata[7];
                        cnt   <= '0;
                    end else begin
                        oe <= 1'b0;
                    end
                end
                S_WORD: if (byte_done) begin
                    ptr <= shreg[AW-1:0];
                    oe  <= 1'b1;
                    cnt <= '0;
                end
                S_WDATA: if (byte_done) begin
                    ptr <= ptr + AW'(1);
                    oe  <= 1'b1;
                    cnt <= '0;
                end
                S_ACK_WORD, S_ACK_WDATA: oe <= 1'b0;
                S_RDATA: begin
                    if (byte_done) begin
                        oe  <= 1'b0;
                        ptr <= ptr + AW'(1);
                    end else begin
                        shreg <= {shreg[6:0], 1'b0};
                        oe    <= ~shreg[6];
                    end
                end
                S_MACK: if (!nack) begin
                    shreg <= rdata;
                    oe    <= ~rdata[7];
                    cnt   <= '0;
                end
                default: ;
            endcase
        end
    end

    assign sda_oe = oe;
endmodule

// File: rtl/spd_checker.sv
module spd_checker
    import spd_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stop_det,
    input logic          scl_lvl,
    input logic          sda_oe,
    input logic          wp,
    input logic          checksum_ok,
    input spd_state_e    state,
    input logic [AW-1:0] ptr
);
    p_release_on_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_lvl);

    p_wp_csum_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wp && $past(wp)) |-> $stable(checksum_ok));

    p_read_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MACK && $past(state) == S_RDATA) |-> (ptr == AW'($past(ptr) + 1'b1)));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !sda_oe);
endmodule

bind spd_serial_store spd_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .stop_det(stop_det), .scl_lvl(scl_lvl),
    .sda_oe(sda_oe), .wp(wp), .checksum_ok(checksum_ok),
    .state(state), .ptr(ptr)
);

// File: tb/spd_serial_store_test.sv
module spd_serial_store_test;
    localparam int HP = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic [2:0] sa = 3'b101;
    logic       wp = 1'b0;
    logic       sda_oe, csum_ok, sda_bus;

    always #10 clk = ~clk;
    assign sda_bus = ~(m_low | sda_oe);

    spd_serial_store uut (
        .clk(clk), .rst_n(rst_n), .scl(scl), .sda_in(sda_bus), .sda_oe(sda_oe),
        .sa(sa), .wp(wp), .checksum_ok(csum_ok)
    );

    int         n_cmp = 0, n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] got;
    bit         scoring = 1'b1;
    bit         done = 1'b0;
    event       ev_byte;

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected bytes as read data is produced
    initial forever begin
        @(ev_byte);
        if (scoring) begin
            if (exp_q.size() == 0) check("scoreboard underrun", 1, 0);
            else check(tag_q.pop_front(), got, exp_q.pop_front());
        end
    end

    task automatic expect_byte(input logic [7:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; wt(HP); scl = 1'b1; wt(HP); m_low = 1'b1; wt(HP); scl = 1'b0; wt(2);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wt(HP); scl = 1'b1; wt(HP); m_low = 1'b0; wt(HP);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; wt(HP); scl = 1'b1; wt(HP); scl = 1'b0; wt(2);
        end
        m_low = 1'b0; wt(HP); scl = 1'b1; wt(HP/2);
        ack = ~sda_bus;
        wt(HP/2); scl = 1'b0; wt(2);
    endtask

    task automatic recv_byte(input bit nack);
        m_low = 1'b0;
        for (int i = 0; i < 8; i++) begin
            wt(HP); scl = 1'b1; wt(HP/2);
            got = {got[6:0], sda_bus};
            wt(HP/2); scl = 1'b0; wt(2);
        end
        -> ev_byte;
        m_low = ~nack; wt(HP); scl = 1'b1; wt(HP); scl = 1'b0; wt(2);
        m_low = 1'b0;
    endtask

    task automatic set_ptr(input logic [7:0] word);
        logic a;
        bus_start();
        send_byte({4'b1010, sa, 1'b0}, a); check("R2 device address write ack", a, 1);
        send_byte(word, a);                check("R2 word address ack", a, 1);
    endtask

    task automatic read_from(input logic [7:0] word, input int n);
        logic a;
        set_ptr(word);
        bus_start();
        send_byte({4'b1010, sa, 1'b1}, a); check("R10 repeated start read ack", a, 1);
        for (int k = 0; k < n; k++) recv_byte(k == n - 1);
        wt(HP);
        check("R11 released after NACK", sda_oe, 0);
        bus_stop();
    endtask

    task automatic write_to(input logic [7:0] word, input logic [7:0] data, input string tag);
        logic a;
        set_ptr(word);
        send_byte(data, a); check(tag, a, 1);
        bus_stop();
        check("R10 released after STOP", sda_oe, 0);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic       a;
        logic [7:0] sum;
        wt(5);
        rst_n = 1'b1;
        wt(5);
        // R1 reset state
        check("R1 sda_oe after reset", sda_oe, 0);
        check("R1 checksum_ok after reset", csum_ok, 1);

        // R2 foreign addresses are ignored
        bus_start();
        send_byte({4'b1010, 3'b000, 1'b0}, a); check("R2 wrong strap no ack", a, 0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, sa, 1'b1}, a); check("R2 wrong type no ack", a, 0);
        check("R2 line released", sda_oe, 0);
        bus_stop();

        // R3 preset bytes, random reads
        expect_byte(8'h80, "R3 byte 0"); expect_byte(8'h08, "R3 byte 1");
        expect_byte(8'h04, "R3 byte 2"); expect_byte(8'h0C, "R3 byte 3");
        expect_byte(8'h09, "R3 byte 4"); expect_byte(8'h02, "R3 byte 5");
        expect_byte(8'h40, "R3 byte 6");
        read_from(8'd0, 7);
        expect_byte(8'h12, "R3 byte 62");
        read_from(8'd62, 1);

        // R4 regions
        expect_byte(8'hFF, "R4 byte 64");  read_from(8'd64, 1);
        expect_byte(8'hFF, "R4 byte 100"); read_from(8'd100, 1);
        expect_byte(8'hFF, "R4 byte 125"); read_from(8'd125, 1);
        expect_byte(8'h00, "R4 byte 128"); read_from(8'd128, 1);
        expect_byte(8'h00, "R4 byte 200"); read_from(8'd200, 1);

        // R5 checksum byte via sequential read of 0..63
        scoring = 1'b0;
        sum = 8'h00;
        set_ptr(8'd0);
        bus_start();
        send_byte({4'b1010, sa, 1'b1}, a); check("R5 read ack", a, 1);
        for (int k = 0; k < 63; k++) begin recv_byte(1'b0); sum = sum + got; end
        recv_byte(1'b1);
        bus_stop();
        scoring = 1'b1;
        check("R5 byte 63 equals sum of 0..62", got, sum);

        // R6 wrap from 255 to 0
        expect_byte(8'h00, "R6 byte 254"); expect_byte(8'h00, "R6 byte 255");
        expect_byte(8'h80, "R6 wrap to byte 0"); expect_byte(8'h08, "R6 then byte 1");
        read_from(8'd254, 4);

        // R7 write and read back
        write_to(8'd200, 8'h5A, "R7 data ack");
        expect_byte(8'h5A, "R7 read back byte 200"); read_from(8'd200, 1);
        check("R7 checksum unaffected", csum_ok, 1);

        // R8 write protect
        wp = 1'b1;
        write_to(8'd201, 8'h33, "R8 data acked under wp");
        write_to(8'd10, 8'h00, "R8 data acked under wp csum byte");
        check("R8 checksum unchanged under wp", csum_ok, 1);
        wp = 1'b0;
        expect_byte(8'h00, "R8 byte 201 not stored"); read_from(8'd201, 1);
        expect_byte(8'h60, "R8 byte 10 not stored");  read_from(8'd10, 1);

        // R9 checksum tracking
        write_to(8'd10, 8'h61, "R9 data ack");
        wt(4);
        check("R9 checksum_ok low after change", csum_ok, 0);
        write_to(8'd10, 8'h60, "R9 data ack restore");
        wt(4);
        check("R9 checksum_ok high after restore", csum_ok, 1);

        wt(20);
        check("R10 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule